// File: doc/BRIEF.md
# Row Width Limiter with Blanking Overrun Guard

This block sits behind a pixel scaler and makes every output row carry exactly the configured number of valid pixels. Pixels come in on a line-valid / pixel-valid stream whose row time stays fixed while the scaler thins the valid beats. Each row is cut or extended to the configured width. When a row ends short, the block keeps its output line-valid high after the input line has closed. It fills the missing beats with a programmable fill value, one per clock. Valid pixels beyond the configured width are thrown away, and the output line closes once the count is reached.

Rows are extended into horizontal blanking. If the next input row opens while fill beats are still owed, the blanking interval was too short for the extension. The block then raises a sticky overrun flag and blanks its frame, line and pixel outputs. Software acknowledges with a one-cycle clear pulse. Output resumes at the first input frame start seen after the flag is clear. If the configured width equals the scaled row width, no fill beats occur and the output line closes together with the input line.

Top module: `line_limiter`

## Requirements
- R1: While reset is asserted and after its release, `out_fv`, `out_lv`, `out_pv`, `out_data` and `ovf_flag` are all zero until the input drives them.
- R2: Every output reflects the inputs of the previous clock. An accepted input pixel appears on `out_data` with `out_pv` high one clock after it is presented, and its value is unchanged.
- R3: A row whose input line closes with fewer than `cfg_width` valid pixels gets one fill beat per clock after the input line falls. Each fill beat has `out_pv` high and `out_data` equal to `cfg_pad`, and fill beats continue until the row holds `cfg_width` valid pixels.
- R4: `out_lv` is high from the clock after the input row opens until the clock that carries the row's `cfg_width`-th valid pixel, and it falls one clock later. `out_pv` is never high while `out_lv` is low.
- R5: Input valid pixels that arrive after the row already holds `cfg_width` pixels are dropped: `out_pv` stays low and `out_data` is zero for them.
- R6: The 12-bit pixel counter restarts on every rising edge of `in_lv`. When a row supplies exactly `cfg_width` valid pixels, no fill beats occur.
- R7: A rising edge of `in_lv` while fill beats are still owed for the previous row sets `ovf_flag` one clock later, and the flag stays set until cleared.
- R8: A one-clock high on `ovf_clr` clears `ovf_flag` on the next clock, unless a new overrun occurs in the same clock.
- R9: From the clock after an overrun, `out_fv`, `out_lv` and `out_pv` are held low. They stay low until a rising edge of `in_fv` arrives while `ovf_flag` is already clear, and that frame is passed normally.
- R10: With `cfg_width` equal to zero, no row opens: `out_lv` and `out_pv` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_fv | input | 1 | Frame valid from the scaler |
| in_lv | input | 1 | Line valid from the scaler |
| in_pv | input | 1 | Pixel valid from the scaler |
| in_data | input | PIX_W | Pixel value from the scaler |
| cfg_width | input | 12 | Required valid pixels per output row |
| cfg_pad | input | PIX_W | Value placed on fill beats |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| out_fv | output | 1 | Limited frame valid |
| out_lv | output | 1 | Limited line valid |
| out_pv | output | 1 | Limited pixel valid |
| out_data | output | PIX_W | Limited pixel value |
| ovf_flag | output | 1 | Sticky blanking overrun flag |

## Verification
Every output of this block is registered once, so pixel, fill beat, line close, frame gating and the overrun flag all take effect one clock after the input clock that caused them. The bench therefore advances its reference model on the rising edge using the inputs held there. It compares all five outputs against the model on the following falling edge. Row-level totals of valid beats are checked once the row and its trailing blanking have been driven and the output register has settled, so the fill beats and any dropped pixels are counted in full.

// File: rtl/lim_pkg.sv
package lim_pkg;

    localparam int CNT_W = 12;

    typedef struct packed {
        logic lv;
        logic fv;
    } edge_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             open;
    } row_t;

    typedef struct packed {
        logic ovf;
        logic blank;
    } guard_t;

endpackage

// File: rtl/lim_edge.sv
module lim_edge
    import lim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_lv,
    input  logic in_fv,
    output logic lv_rise,
    output logic fv_rise
);

    edge_t e_d, e_q;

    always_comb begin
        e_d.lv  = in_lv;
        e_d.fv  = in_fv;
        lv_rise = in_lv && !e_q.lv;
        fv_rise = in_fv && !e_q.fv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

endmodule

// File: rtl/lim_row.sv
module lim_row
    import lim_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_lv,
    input  logic             in_pv,
    input  logic [PIX_W-1:0] in_data,
    input  logic             lv_rise,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [PIX_W-1:0] cfg_pad,
    output logic             nxt_lv,
    output logic             nxt_pv,
    output logic [PIX_W-1:0] nxt_data,
    output logic             pad_overrun
);

    row_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        nxt_lv      = 1'b0;
        nxt_pv      = 1'b0;
        nxt_data    = '0;
        // a new row opening while the old one is still owed fill beats
        pad_overrun = lv_rise && r_q.open;
        if (lv_rise) begin
            r_d.cnt  = '0;
            r_d.open = (cfg_width != '0);
        end
        if (r_d.open) begin
            nxt_lv = 1'b1;
            if (in_lv && in_pv) begin
                nxt_pv   = 1'b1;
                nxt_data = in_data;
            end else if (!in_lv) begin
                nxt_pv   = 1'b1;
                nxt_data = cfg_pad;
            end
            if (nxt_pv) begin
                r_d.cnt = r_d.cnt + CNT_W'(1);
                if (r_d.cnt == cfg_width) r_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R6: counter restarts at every input row start
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lv_rise |=> (r_q.cnt <= CNT_W'(1)));

endmodule

// File: rtl/lim_guard.sv
module lim_guard
    import lim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_set,
    input  logic ovf_clr,
    input  logic fv_rise,
    output logic ovf_flag,
    output logic gate_off
);

    guard_t g_d, g_q;

    always_comb begin
        g_d.ovf = ovf_set || (g_q.ovf && !ovf_clr);
        if (ovf_set)
            g_d.blank = 1'b1;
        else if (g_q.blank && fv_rise && !g_q.ovf)
            g_d.blank = 1'b0;
        else
            g_d.blank = g_q.blank;
        ovf_flag = g_q.ovf;
        gate_off = g_d.blank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> g_q.ovf);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.ovf && !ovf_clr) |=> g_q.ovf);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_set) |=> !g_q.ovf);

endmodule

// File: rtl/line_limiter.sv
module line_limiter
    import lim_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fv,
    input  logic             in_lv,
    input  logic             in_pv,
    input  logic [PIX_W-1:0] in_data,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [PIX_W-1:0] cfg_pad,
    input  logic             ovf_clr,
    output logic             out_fv,
    output logic             out_lv,
    output logic             out_pv,
    output logic [PIX_W-1:0] out_data,
    output logic             ovf_flag
);

    typedef struct packed {
        logic             fv;
        logic             lv;
        logic             pv;
        logic [PIX_W-1:0] data;
    } stream_t;

    logic             lv_rise, fv_rise;
    logic             nxt_lv, nxt_pv, pad_overrun, gate_off;
    logic [PIX_W-1:0] nxt_data;
    stream_t          o_d, o_q;

    lim_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_lv   (in_lv),
        .in_fv   (in_fv),
        .lv_rise (lv_rise),
        .fv_rise (fv_rise)
    );

    lim_row #(.PIX_W(PIX_W)) u_row (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_lv       (in_lv),
        .in_pv       (in_pv),
        .in_data     (in_data),
        .lv_rise     (lv_rise),
        .cfg_width   (cfg_width),
        .cfg_pad     (cfg_pad),
        .nxt_lv      (nxt_lv),
        .nxt_pv      (nxt_pv),
        .nxt_data    (nxt_data),
        .pad_overrun (pad_overrun)
    );

    lim_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_set  (pad_overrun),
        .ovf_clr  (ovf_clr),
        .fv_rise  (fv_rise),
        .ovf_flag (ovf_flag),
        .gate_off (gate_off)
    );

    always_comb begin
        o_d.fv   = in_fv  && !gate_off;
        o_d.lv   = nxt_lv && !gate_off;
        o_d.pv   = nxt_pv && !gate_off;
        o_d.data = gate_off ? '0 : nxt_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_fv   = o_q.fv;
    assign out_lv   = o_q.lv;
    assign out_pv   = o_q.pv;
    assign out_data = o_q.data;

    // R4: a valid beat only inside an open output line
    p_pv_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_pv |-> out_lv);

    // R9: nothing leaves the block while the overrun flag is up
    p_blanked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (!out_fv && !out_lv && !out_pv));

endmodule

// File: tb/tb_line_limiter.sv
module tb_line_limiter;

    localparam int PW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_fv = 1'b0, in_lv = 1'b0, in_pv = 1'b0, ovf_clr = 1'b0;
    logic [PW-1:0] in_data = '0, cfg_pad = '0;
    logic [11:0]   cfg_width = '0;
    logic          out_fv, out_lv, out_pv, ovf_flag;
    logic [PW-1:0] out_data;

    always #4 clk = ~clk;

    line_limiter #(.PIX_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .in_fv(in_fv), .in_lv(in_lv), .in_pv(in_pv),
        .in_data(in_data), .cfg_width(cfg_width), .cfg_pad(cfg_pad), .ovf_clr(ovf_clr),
        .out_fv(out_fv), .out_lv(out_lv), .out_pv(out_pv), .out_data(out_data),
        .ovf_flag(ovf_flag)
    );

    int checks = 0, fails = 0, cycles = 0, pv_seen = 0, dval = 1;
    bit done = 1'b0;

    // behavioural reference
    int m_left;
    bit m_open, m_lvp, m_fvp, m_ovf, m_blank;
    bit e_fv, e_lv, e_pv, e_ovf;
    int e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_open = 0; m_lvp = 0; m_fvp = 0; m_ovf = 0; m_blank = 0;
            e_fv = 0; e_lv = 0; e_pv = 0; e_ovf = 0; e_data = 0;
        end else begin
            bit rise, frise, hit, pv_o, old_ovf;
            int d_o;
            rise  = in_lv && !m_lvp;
            frise = in_fv && !m_fvp;
            hit   = rise && m_open;
            pv_o  = 0; d_o = 0;
            if (rise) begin
                m_left = cfg_width;
                m_open = (cfg_width != 0);
            end
            e_lv = m_open;
            if (m_open) begin
                if (in_lv && in_pv) begin pv_o = 1; d_o = in_data; end
                else if (!in_lv)    begin pv_o = 1; d_o = cfg_pad; end
                if (pv_o) begin
                    m_left--;
                    if (m_left == 0) m_open = 0;
                end
            end
            old_ovf = m_ovf;
            m_ovf = hit || (m_ovf && !ovf_clr);
            if (hit) m_blank = 1;
            else if (m_blank && frise && !old_ovf) m_blank = 0;
            e_fv   = in_fv && !m_blank;
            e_lv   = e_lv && !m_blank;
            e_pv   = pv_o && !m_blank;
            e_data = m_blank ? 0 : d_o;
            e_ovf  = m_ovf;
            m_lvp  = in_lv;
            m_fvp  = in_fv;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // clock-by-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk(out_lv == e_lv, "R4", "out_lv", out_lv, e_lv);
            chk(out_pv == e_pv, "R2", "out_pv", out_pv, e_pv);
            chk(int'(out_data) == e_data, "R3", "out_data", out_data, e_data);
            chk(out_fv == e_fv, "R9", "out_fv", out_fv, e_fv);
            chk(ovf_flag == e_ovf, "R7", "ovf_flag", ovf_flag, e_ovf);
            if (out_pv) pv_seen++;
        end
    end

    initial begin
        wait (cycles > 50000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic row(input int n, input bit sparse, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_lv   = 1'b1;
            in_pv   = sparse ? (i % 2 == 0) : 1'b1;
            in_data = PW'(dval);
            dval    = (dval + 7) % 1000 + 1;
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_lv = 1'b0; in_pv = 1'b0; in_data = '0;
        end
    endtask

    task automatic frame_start();
        @(negedge clk); in_fv = 1'b0;
        @(negedge clk);
        @(negedge clk); in_fv = 1'b1;
    endtask

    initial begin
        cfg_width = 12'd8;
        cfg_pad   = 10'h155;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_fv == 0 && out_lv == 0 && out_pv == 0, "R1", "stream in reset",
            {out_fv, out_lv, out_pv}, 0);
        chk(out_data == 0 && ovf_flag == 0, "R1", "data/flag in reset", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_lv == 0 && ovf_flag == 0, "R1", "after release", out_lv, 0);
        frame_start();

        // R6: exact width, no fill beats
        pv_seen = 0; row(8, 1'b0, 6);
        chk(pv_seen == 8, "R6", "beats in exact row", pv_seen, 8);

        // R3: 2:1 thinned row padded into blanking
        pv_seen = 0; row(8, 1'b1, 10);
        chk(pv_seen == 8, "R3", "beats in padded row", pv_seen, 8);

        // R5: long row truncated
        pv_seen = 0; row(12, 1'b0, 6);
        chk(pv_seen == 8, "R5", "beats in long row", pv_seen, 8);

        // R4: padded row with a narrower width
        cfg_width = 12'd3;
        pv_seen = 0; row(2, 1'b0, 5);
        chk(pv_seen == 3, "R4", "beats with width 3", pv_seen, 3);
        cfg_width = 12'd8;

        // R7: blanking too short for the fill beats
        row(8, 1'b1, 2);
        row(8, 1'b0, 6);
        chk(ovf_flag == 1, "R7", "flag after overrun", ovf_flag, 1);
        pv_seen = 0; row(8, 1'b0, 6);
        chk(pv_seen == 0, "R9", "beats while flagged", pv_seen, 0);
        chk(out_fv == 0, "R9", "frame valid while flagged", out_fv, 0);

        // R8: clear pulse
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk(ovf_flag == 0, "R8", "flag after clear", ovf_flag, 0);
        pv_seen = 0; row(8, 1'b0, 6);
        chk(pv_seen == 0, "R9", "still blank before frame start", pv_seen, 0);
        frame_start();
        pv_seen = 0; row(8, 1'b0, 6);
        chk(pv_seen == 8, "R9", "beats after new frame", pv_seen, 8);
        chk(out_fv == 1, "R9", "frame valid resumed", out_fv, 1);

        // R10: zero width
        cfg_width = 12'd0;
        pv_seen = 0; row(8, 1'b0, 6);
        chk(pv_seen == 0, "R10", "beats at width 0", pv_seen, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule